// File: doc/BRIEF.md
# Dual-Compare Toggling PWM Counter

A single counter channel that shapes a pulse-width-modulated waveform from two compare values instead of a period/duty pair. In alternating mode the output flag stays low until the count reaches compare 1, toggles high, and then stays high until the count reaches compare 2. Each toggle reinitialises the counter from a load value. The two phases therefore last compare 1 plus one and compare 2 plus one count ticks. Each compare register has a preload shadow. The shadow is copied in when the *other* compare matches, so software can change the duty of the next phase while the current phase completes at its old length.

The counter advances only on cycles where the count-enable input is high. Outside alternating mode the channel is a plain up or down counter. Its period match comes from compare 1 when counting up and from compare 2 when counting down. It can reload on a match or wrap freely, and it flags overflow when it wraps.

Status is held in sticky flags, each with its own enable. The interrupt line is the OR of the enabled flags. An output-enable bit gates the pin, a polarity bit inverts it, and a write-pulse force bit drives the internal flag low before a waveform starts.

Top module: `dcmp_pwm_timer`

## Requirements
- R1: After reset every register reads 0, and `pwm_o`, `pwm_oe_o` and `irq_o` are low.
- R2: Register addresses are: 0 compare 1, 1 compare 2, 2 preload 1, 3 preload 2, 4 load value, 5 count, 6 control, 7 flags. Writes take effect at the clock edge and reads are combinational. In control, bits [1:0] are mode, bit 2 is reinit-on-match, bit 3 is count down, bit 4 is output enable, bit 5 is force, bit 6 is invert, and bits [11:8] are the flag enables. The force bit always reads 0.
- R3: Mode 0 (and the reserved mode 3) holds the count at its value even with count enable high.
- R4: Mode 1 counting up matches when count equals compare 1. On a match with reinit set, the next count is the load value; otherwise the counter increments.
- R5: Mode 1 counting down matches only against compare 2 and ignores compare 1.
- R6: The overflow flag sets when the counter wraps (0xFFFF to 0 up, 0 to 0xFFFF down) without a reinit.
- R7: Mode 2 with reinit and load 0 gives a low phase of compare 1 + 1 ticks and a high phase of compare 2 + 1 ticks. Each match toggles the flag.
- R8: Compare 1 takes preload 1 when compare 2 matches. Compare 2 takes preload 2 when compare 1 matches. A preload write never alters a phase in progress.
- R9: Writing force clears the output flag. `pwm_o` is the flag XOR invert, gated low when output enable is 0. `pwm_oe_o` mirrors output enable.
- R10: Flag bits are 0 general compare, 1 overflow, 2 compare 1, 3 compare 2. They are sticky. Writing 0 to a bit clears it and writing 1 has no effect. A match in the clear cycle keeps the flag set.
- R11: `irq_o` is high when any flag is set together with its enable bit (control bit 8 + flag index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count tick enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| pwm_o | output | 1 | Gated, polarity-adjusted output flag |
| pwm_oe_o | output | 1 | Output driver enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The alternating mode is checked against a cycle-exact expectation of 3-low/5-high phases over three full periods. A slip of one count in either compare path or in the reload shows up there. A preload write placed inside a running high phase tells a shadowed design from one that applies writes at once: the current phase must keep its old length and only the following phase may change. Up, down and free-running patterns separate the choice of compare by direction and the wrap-versus-reinit paths. A permanent match, with the clear written in the same cycle, shows which of set and clear wins.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int ADDR_W  = 3;
  localparam int N_FLAGS = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CMP1 = 3'd0, A_CMP2 = 3'd1, A_PRE1 = 3'd2, A_PRE2 = 3'd3,
    A_LOAD = 3'd4, A_CNT  = 3'd5, A_CTRL = 3'd6, A_FLAG = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0, MODE_COUNT = 2'd1, MODE_ALT = 2'd2, MODE_RSVD = 2'd3
  } cnt_mode_e;

  // control bit positions
  localparam int C_LEN    = 2;
  localparam int C_DN     = 3;
  localparam int C_OE     = 4;
  localparam int C_FRC    = 5;
  localparam int C_POL    = 6;
  localparam int C_IEN_LO = 8;

  // flag bit positions
  localparam int F_CMP  = 0;
  localparam int F_OVF  = 1;
  localparam int F_CMP1 = 2;
  localparam int F_CMP2 = 3;
endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic                 ev1_i,
  input  logic                 ev2_i,
  input  logic [W-1:0]         cnt_i,
  input  logic [N_FLAGS-1:0]   flags_i,
  output logic [W-1:0]         cmp1_o,
  output logic [W-1:0]         cmp2_o,
  output logic [W-1:0]         pre1_o,
  output logic [W-1:0]         pre2_o,
  output logic [W-1:0]         load_o,
  output logic [W-1:0]         ctrl_o,
  output logic                 force_o,
  output logic                 cnt_wr_o,
  output logic                 flag_wr_o,
  output logic [W-1:0]         rdata_o
);
  localparam int NREG = 1 << ADDR_W;
  localparam logic [W-1:0] FRC_MASK = W'(1) << C_FRC;

  logic [NREG-1:0] wsel;
  assign wsel = we_i ? (NREG'(1) << addr_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp1_o <= '0;
      cmp2_o <= '0;
      pre1_o <= '0;
      pre2_o <= '0;
      load_o <= '0;
      ctrl_o <= '0;
    end else begin
      // software write wins over a preload transfer in the same cycle
      if (wsel[A_CMP1])  cmp1_o <= wdata_i;
      else if (ev2_i)    cmp1_o <= pre1_o;
      if (wsel[A_CMP2])  cmp2_o <= wdata_i;
      else if (ev1_i)    cmp2_o <= pre2_o;
      if (wsel[A_PRE1])  pre1_o <= wdata_i;
      if (wsel[A_PRE2])  pre2_o <= wdata_i;
      if (wsel[A_LOAD])  load_o <= wdata_i;
      if (wsel[A_CTRL])  ctrl_o <= wdata_i & ~FRC_MASK;
    end
  end

  assign force_o   = wsel[A_CTRL] && wdata_i[C_FRC];
  assign cnt_wr_o  = wsel[A_CNT];
  assign flag_wr_o = wsel[A_FLAG];

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CMP1:  rdata_o = cmp1_o;
      A_CMP2:  rdata_o = cmp2_o;
      A_PRE1:  rdata_o = pre1_o;
      A_PRE2:  rdata_o = pre2_o;
      A_LOAD:  rdata_o = load_o;
      A_CNT:   rdata_o = cnt_i;
      A_CTRL:  rdata_o = ctrl_o;
      A_FLAG:  rdata_o = W'(flags_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dpt_core.sv
module dpt_core
  import dpt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  cnt_mode_e     mode_i,
  input  logic          length_i,
  input  logic          dn_i,
  input  logic [W-1:0]  cmp1_i,
  input  logic [W-1:0]  cmp2_i,
  input  logic [W-1:0]  load_i,
  input  logic          cnt_wr_i,
  input  logic [W-1:0]  cnt_wdata_i,
  input  logic          force_i,
  output logic [W-1:0]  cnt_o,
  output logic          oflag_o,
  output logic          ev1_o,
  output logic          ev2_o,
  output logic          ovf_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         oflag_q, oflag_d;
  logic         run, alt, up, hit, reinit;

  always_comb begin
    run    = tick_i && (mode_i == MODE_COUNT || mode_i == MODE_ALT);
    alt    = mode_i == MODE_ALT;
    up     = alt || !dn_i;
    ev1_o  = 1'b0;
    ev2_o  = 1'b0;
    if (run) begin
      if (alt) begin
        // low phase watches compare 1, high phase compare 2
        ev1_o = !oflag_q && (cnt_q == cmp1_i);
        ev2_o =  oflag_q && (cnt_q == cmp2_i);
      end else if (dn_i) begin
        ev2_o = cnt_q == cmp2_i;
      end else begin
        ev1_o = cnt_q == cmp1_i;
      end
    end
    hit    = ev1_o || ev2_o;
    reinit = hit && length_i;
    ovf_o  = run && !reinit && (up ? (cnt_q == CNT_MAX) : (cnt_q == '0));

    cnt_d = cnt_q;
    if (cnt_wr_i)  cnt_d = cnt_wdata_i;
    else if (run)  cnt_d = reinit ? load_i : (up ? cnt_q + W'(1) : cnt_q - W'(1));

    oflag_d = force_i ? 1'b0 : (hit ? !oflag_q : oflag_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      oflag_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      oflag_q <= oflag_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign oflag_o = oflag_q;
endmodule

// File: rtl/dpt_flags.sv
module dpt_flags #(
  parameter int N = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic          clr_wr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  ien_i,
  output logic [N-1:0]  flags_o,
  output logic          irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flags_o[i] <= 1'b0;
      else if (set_i[i])                flags_o[i] <= 1'b1;
      else if (clr_wr_i && !wdata_i[i]) flags_o[i] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & ien_i);
endmodule

// File: rtl/dcmp_pwm_timer.sv
module dcmp_pwm_timer
  import dpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]   cmp1, cmp2, pre1, pre2, load, ctrl, cnt;
  logic               force_p, cnt_wr, flag_wr;
  logic               ev1, ev2, ovf, oflag;
  logic [N_FLAGS-1:0] flags, flag_set, ien;
  logic [1:0]         mode_w;
  logic               len_w, dn_w, oe_w, pol_w;
  logic               cmp1_wr, cmp2_wr;

  assign mode_w  = ctrl[1:0];
  assign len_w   = ctrl[C_LEN];
  assign dn_w    = ctrl[C_DN];
  assign oe_w    = ctrl[C_OE];
  assign pol_w   = ctrl[C_POL];
  assign ien     = ctrl[C_IEN_LO +: N_FLAGS];
  assign cmp1_wr = bus_we_i && (bus_addr_i == A_CMP1);
  assign cmp2_wr = bus_we_i && (bus_addr_i == A_CMP2);

  dpt_regs #(.W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .ev1_i(ev1), .ev2_i(ev2), .cnt_i(cnt), .flags_i(flags),
    .cmp1_o(cmp1), .cmp2_o(cmp2), .pre1_o(pre1), .pre2_o(pre2), .load_o(load),
    .ctrl_o(ctrl), .force_o(force_p), .cnt_wr_o(cnt_wr), .flag_wr_o(flag_wr),
    .rdata_o(bus_rdata_o)
  );

  dpt_core #(.W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(cnt_en_i), .mode_i(cnt_mode_e'(mode_w)),
    .length_i(len_w), .dn_i(dn_w), .cmp1_i(cmp1), .cmp2_i(cmp2), .load_i(load),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(bus_wdata_i), .force_i(force_p),
    .cnt_o(cnt), .oflag_o(oflag), .ev1_o(ev1), .ev2_o(ev2), .ovf_o(ovf)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[F_CMP]  = ev1 || ev2;
    flag_set[F_OVF]  = ovf;
    flag_set[F_CMP1] = ev1;
    flag_set[F_CMP2] = ev2;
  end

  dpt_flags #(.N(N_FLAGS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .clr_wr_i(flag_wr),
    .wdata_i(bus_wdata_i[N_FLAGS-1:0]), .ien_i(ien), .flags_o(flags), .irq_o(irq_o)
  );

  assign pwm_o    = oe_w && (oflag ^ pol_w);
  assign pwm_oe_o = oe_w;
endmodule

// File: rtl/dpt_chk.sv
module dpt_chk
  import dpt_pkg::*;
#(
  parameter int W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic               length_i,
  input logic               oe_i,
  input logic               pwm_i,
  input logic               irq_i,
  input logic [W-1:0]       cnt_i,
  input logic [W-1:0]       load_i,
  input logic [W-1:0]       cmp1_i,
  input logic [W-1:0]       pre1_i,
  input logic [W-1:0]       cmp2_i,
  input logic [W-1:0]       pre2_i,
  input logic               ev1_i,
  input logic               ev2_i,
  input logic [N_FLAGS-1:0] flags_i,
  input logic               cnt_wr_i,
  input logic               flag_wr_i,
  input logic               cmp1_wr_i,
  input logic               cmp2_wr_i
);
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !cnt_wr_i) |=> $stable(cnt_i)); // R3

  AST_LEN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev1_i || ev2_i) && length_i && !cnt_wr_i) |=> (cnt_i == $past(load_i))); // R4

  AST_RELOAD_CMP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev2_i && !cmp1_wr_i) |=> (cmp1_i == $past(pre1_i))); // R8

  AST_RELOAD_CMP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev1_i && !cmp2_wr_i) |=> (cmp2_i == $past(pre2_i))); // R8

  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !pwm_i); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr_i |=> ((flags_i & $past(flags_i)) == $past(flags_i))); // R10

  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |-> !irq_i); // R11
endmodule

bind dcmp_pwm_timer dpt_chk #(.W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_w), .length_i(len_w), .oe_i(oe_w),
  .pwm_i(pwm_o), .irq_i(irq_o), .cnt_i(cnt), .load_i(load), .cmp1_i(cmp1),
  .pre1_i(pre1), .cmp2_i(cmp2), .pre2_i(pre2), .ev1_i(ev1), .ev2_i(ev2),
  .flags_i(flags), .cnt_wr_i(cnt_wr), .flag_wr_i(flag_wr), .cmp1_wr_i(cmp1_wr),
  .cmp2_wr_i(cmp2_wr)
);

// File: tb/dcmp_pwm_timer_test.sv
`timescale 1ns/1ps
module dcmp_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm, pwm_oe, irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  localparam logic [2:0] CMP1 = 3'd0, CMP2 = 3'd1, PRE1 = 3'd2, PRE2 = 3'd3,
                         LOAD = 3'd4, CNT = 3'd5, CTRL = 3'd6, FLAG = 3'd7;

  always #5 clk = ~clk;

  dcmp_pwm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pwm_o(pwm), .pwm_oe_o(pwm_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 pwm_o", pwm, 0);
    chk("R1 pwm_oe_o", pwm_oe, 0);
    chk("R1 irq_o", irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 register", v, 0);
    end
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(CMP1, 16'h1234); wr(PRE2, 16'hBEEF); wr(LOAD, 16'h0007); wr(CTRL, 16'h0F7C);
    rd(CMP1, v); chk("R2 cmp1", v, 16'h1234);
    rd(PRE2, v); chk("R2 pre2", v, 16'hBEEF);
    rd(LOAD, v); chk("R2 load", v, 16'h0007);
    rd(CTRL, v); chk("R2 ctrl force reads 0", v, 16'h0F5C);
    wr(CTRL, 16'h0000);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr(CNT, 16'h0055);
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    rd(CNT, v); chk("R3 mode0 hold", v, 16'h0055);
    wr(CTRL, 16'h0003);
    repeat (5) @(negedge clk);
    rd(CNT, v); chk("R3 mode3 hold", v, 16'h0055);
    cnt_en = 1'b0;
    wr(CTRL, 16'h0000);
  endtask

  task automatic t_out;
    wr(CTRL, 16'h0030);
    chk("R9 force low", pwm, 0);
    chk("R9 oe out", pwm_oe, 1);
    wr(CTRL, 16'h0050);
    chk("R9 invert", pwm, 1);
    wr(CTRL, 16'h0040);
    chk("R9 gated", pwm, 0);
    chk("R9 oe off", pwm_oe, 0);
  endtask

  task automatic t_up;
    logic [15:0] v;
    wr(CTRL, 16'h0000); wr(CNT, 16'h0000); wr(CMP1, 16'h0003); wr(LOAD, 16'h0001);
    wr(FLAG, 16'h0000); wr(CTRL, 16'h0005);
    ticks(3);
    rd(CNT, v); chk("R4 up count", v, 16'h0003);
    rd(FLAG, v); chk("R4 no match yet", v, 16'h0000);
    ticks(1);
    rd(CNT, v); chk("R4 reinit to load", v, 16'h0001);
    rd(FLAG, v); chk("R4 R10 cmp+cmp1 flags", v, 16'h0005);
  endtask

  task automatic t_down;
    logic [15:0] v;
    wr(CTRL, 16'h0000); wr(LOAD, 16'h0003); wr(CNT, 16'h0003); wr(CMP1, 16'h0002);
    wr(CMP2, 16'h0000); wr(FLAG, 16'h0000); wr(CTRL, 16'h000D);
    ticks(3);
    rd(CNT, v); chk("R5 down count", v, 16'h0000);
    rd(FLAG, v); chk("R5 cmp1 ignored", v, 16'h0000);
    ticks(1);
    rd(CNT, v); chk("R5 reinit", v, 16'h0003);
    rd(FLAG, v); chk("R5 cmp2 flags", v, 16'h0009);
  endtask

  task automatic t_ovf;
    logic [15:0] v;
    wr(CTRL, 16'h0000); wr(CMP1, 16'h1000); wr(CNT, 16'hFFFE); wr(FLAG, 16'h0000);
    wr(CTRL, 16'h0201);
    chk("R11 irq idle", irq, 0);
    ticks(2);
    rd(CNT, v); chk("R6 wrap", v, 16'h0000);
    rd(FLAG, v); chk("R6 ovf flag", v, 16'h0002);
    chk("R11 irq on", irq, 1);
    wr(CTRL, 16'h0001);
    chk("R11 irq masked", irq, 0);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(CTRL, 16'h0000); wr(CMP1, 16'h0000); wr(LOAD, 16'h0000); wr(CNT, 16'h0000);
    wr(FLAG, 16'h0000); wr(CTRL, 16'h0005);
    cnt_en = 1'b1;
    repeat (2) @(negedge clk);
    rd(FLAG, v); chk("R10 set", v, 16'h0005);
    wr(FLAG, 16'h0000);
    rd(FLAG, v); chk("R10 match beats clear", v, 16'h0005);
    cnt_en = 1'b0;
    wr(FLAG, 16'h000F);
    rd(FLAG, v); chk("R10 write 1 no effect", v, 16'h0005);
    wr(FLAG, 16'h0001);
    rd(FLAG, v); chk("R10 clear one bit", v, 16'h0001);
  endtask

  task automatic t_pwm;
    logic [15:0] v;
    int bad = 0;
    int n = 0, m = 0, h = 0, l = 0;
    wr(CTRL, 16'h0000); wr(CNT, 16'h0000); wr(LOAD, 16'h0000);
    wr(CMP1, 16'd2); wr(CMP2, 16'd4); wr(PRE1, 16'd2); wr(PRE2, 16'd4);
    wr(FLAG, 16'h0000);
    cnt_en = 1'b1;
    wr(CTRL, 16'h0036);
    for (int j = 0; j < 24; j++) begin
      if (pwm != ((j % 8) >= 3)) bad++;
      @(negedge clk);
    end
    chk("R7 3-low 5-high waveform mismatches", bad, 0);
    while (!pwm) @(negedge clk);
    n = 1;
    wr(PRE2, 16'd1);
    while (pwm)  begin n++; @(negedge clk); end
    while (!pwm) begin m++; @(negedge clk); end
    while (pwm)  begin h++; @(negedge clk); end
    chk("R8 running high keeps old length", n, 5);
    chk("R7 low phase", m, 3);
    chk("R8 next high uses new preload", h, 2);
    wr(PRE1, 16'd5);
    rd(CMP1, v); chk("R8 cmp1 not yet reloaded", v, 16'd2);
    while (!pwm) @(negedge clk);
    while (pwm)  @(negedge clk);
    rd(CMP1, v); chk("R8 cmp1 reloaded at cmp2 match", v, 16'd5);
    while (!pwm) begin l++; @(negedge clk); end
    chk("R8 R7 new low phase", l, 6);
    cnt_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_regs; t_stop; t_out; t_up; t_down; t_ovf; t_race; t_pwm;
    finish_run;
  end

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule